// File: doc/BRIEF.md
# Temperature Alarm and Status Logic

This block sits behind a two-channel temperature converter and turns each finished reading into alarm state. Every time the converter reports a completed conversion, the block tags it as local or remote, compares it as a signed 8-bit value against that channel's high limit and against one critical limit shared by both channels, and updates five sticky status flags. A remote input that is reported open is treated as a reading of +127 and also sets its own flag.

Two open-drain style alarm outputs are produced as pull-down enables. The interrupt follows the high flags and can be masked or made active high. The critical alarm follows the critical flags through per-channel masks. The masks only gate the pins; the flags behind them are set regardless. A flag is cleared only by a status-read pulse, and only when the most recent comparison for that flag no longer exceeds its limit.

Top module: `thermal_alarm`

## Requirements
- R1: While reset is held, and right after it, the status byte is 00h and both drive enables are 0 (with config 00h).
- R2: Status bit positions: bit 0 local critical, bit 1 remote critical, bit 2 remote open, bit 4 remote high, bit 6 local high; bits 3, 5 and 7 always read 0.
- R3: A comparison happens only on a completion strobe (`conv_chan` 0 = local, 1 = remote) and sets its flag only when the reading is strictly greater than the limit in signed two's complement; the status byte shows it in the cycle after the strobe.
- R4: A set flag stays set while no status read occurs, whatever later readings are.
- R5: A status read clears a flag only if the latest comparison for that flag did not exceed its limit (or, for the open flag, the latest remote conversion was not open); otherwise the flag stays set.
- R6: A status read arriving in the same cycle as a conversion that exceeds the limit leaves that flag set.
- R7: The interrupt is active when bit 4 or bit 6 of status is set and config bit 7 is 0; config bit 7 = 1 keeps it inactive while the status bits still set.
- R8: With config bit 1 = 0 the interrupt is active low (`int_drive_en` = 1 while active); with config bit 1 = 1 it is active high (`int_drive_en` = 1 while inactive).
- R9: `crit_drive_en` is 1 when local critical is set and config bit 2 is 0, or remote critical is set and config bits 3, 4 and 5 are all 0; masked flags still appear in status.
- R10: A remote conversion with `conv_open` = 1 sets the open flag and is compared as +127 (7Fh), so remote critical sets whenever the critical limit is below 127.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| conv_done | input | 1 | One-cycle strobe: a conversion finished |
| conv_chan | input | 1 | Channel of the finished conversion, 0 local, 1 remote |
| conv_value | input | 8 | Signed reading, 1 degree per LSB |
| conv_open | input | 1 | Remote input found open during this conversion |
| lim_local_high | input | 8 | Signed local high limit |
| lim_remote_high | input | 8 | Signed remote high limit |
| lim_crit | input | 8 | Signed critical limit shared by both channels |
| cfg | input | 8 | Configuration byte (masks and interrupt polarity) |
| stat_rd | input | 1 | One-cycle pulse: the status byte is being read |
| status | output | 8 | Sticky status byte |
| int_drive_en | output | 1 | Pull-down enable for the interrupt pin |
| crit_drive_en | output | 1 | Pull-down enable for the critical alarm pin |

## Verification
On every cycle the assertions check that no flag rises without an exceeding comparison, that none falls without a status read, that a coincident read cannot undo a fresh exceedance, and that the pin enables agree with the status byte, the masks and the polarity bit. What only the bench scenarios show is the full clear-on-read rule against the latest reading, the signed boundary at equality and across zero, each of the three remote critical masks separately, and the open-input path at critical limits of 100 and 127.

// File: rtl/thermal_alarm_pkg.sv
// Package: shared constants for the temperature alarm block.
// Assumes 8-bit status and configuration bytes with fixed bit meanings.
package thermal_alarm_pkg;
    localparam int STAT_W   = 8;
    localparam int CFG_W    = 8;
    localparam int NUM_FLAG = 5;
    localparam int NUM_CMP  = 4;

    // status byte bit positions
    localparam int SB_LCRIT = 0;
    localparam int SB_RCRIT = 1;
    localparam int SB_ROPEN = 2;
    localparam int SB_RHIGH = 4;
    localparam int SB_LHIGH = 6;

    // configuration bit positions
    localparam int CB_INT_POL  = 1;
    localparam int CB_LCRIT_MK = 2;
    localparam int CB_RCRIT_MA = 3;
    localparam int CB_RCRIT_MB = 4;
    localparam int CB_RCRIT_MC = 5;
    localparam int CB_INT_MK   = 7;

    // flag slots inside the block
    localparam int FL_LCRIT = 0;
    localparam int FL_RCRIT = 1;
    localparam int FL_ROPEN = 2;
    localparam int FL_RHIGH = 3;
    localparam int FL_LHIGH = 4;

    // comparator slots
    localparam int CM_LCRIT = 0;
    localparam int CM_RCRIT = 1;
    localparam int CM_RHIGH = 2;
    localparam int CM_LHIGH = 3;

    typedef enum logic {
        CH_LOCAL  = 1'b0,
        CH_REMOTE = 1'b1
    } chan_e;
endpackage

// File: rtl/limit_compare.sv
// Module: limit_compare
// Reports whether a reading lies strictly above a limit. SIGNED_CMP=1
// selects two's complement ordering, 0 selects unsigned ordering.
// Assumes reading and limit share the same width and encoding.
module limit_compare #(
    parameter int W          = 8,
    parameter bit SIGNED_CMP = 1'b1
) (
    input  logic [W-1:0] reading,
    input  logic [W-1:0] limit,
    output logic         above
);
    generate
        if (SIGNED_CMP) begin : g_signed
            // signed strict greater-than
            always_comb above = $signed(reading) > $signed(limit);
        end else begin : g_unsigned
            // unsigned strict greater-than
            always_comb above = reading > limit;
        end
    endgenerate
endmodule

// File: rtl/sticky_flag.sv
// Module: sticky_flag
// One status flag: set by an exceeding comparison, cleared by a status
// read only when the latest comparison for it did not exceed. Keeps the
// latest comparison result so a read long after a conversion can decide.
// Assumes evt and rd are single-cycle pulses from the clk domain.
module sticky_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic cond,
    input  logic rd,
    output logic flag
);
    logic cond_q;
    logic cond_now;
    logic flag_d;

    // latest condition, taking a same-cycle conversion into account
    always_comb cond_now = evt ? cond : cond_q;

    // set wins; a read only clears when the latest condition is gone
    always_comb flag_d = (evt & cond) | (flag & ~(rd & ~cond_now));

    // state update with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag   <= 1'b0;
            cond_q <= 1'b0;
        end else begin
            flag   <= flag_d;
            cond_q <= cond_now;
        end
    end

    // R3
    flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(evt && cond));

    // R5
    flag_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag) |-> $past(rd));

    // R4
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !rd) |=> flag);

    // R6
    coincident_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && evt && cond) |=> flag);
endmodule

// File: rtl/alarm_drive.sv
// Module: alarm_drive
// Turns the flags into pull-down enables for two open-drain pins.
// Interrupt: maskable, selectable polarity. Critical: per-channel masks,
// active low. Purely combinational; flags arrive from registers.
module alarm_drive (
    input  logic lhigh,
    input  logic rhigh,
    input  logic lcrit,
    input  logic rcrit,
    input  logic int_mask,
    input  logic int_pol_high,
    input  logic lcrit_mask,
    input  logic rcrit_mask_a,
    input  logic rcrit_mask_b,
    input  logic rcrit_mask_c,
    output logic int_drive_en,
    output logic crit_drive_en
);
    logic int_active;
    logic rcrit_open_path;

    // interrupt is active on any high flag unless masked
    always_comb int_active = (lhigh | rhigh) & ~int_mask;

    // active-high pin pulls low while idle, active-low pulls while active
    always_comb int_drive_en = int_pol_high ? ~int_active : int_active;

    // any of the three remote masks blocks the remote path
    always_comb rcrit_open_path = ~(rcrit_mask_a | rcrit_mask_b | rcrit_mask_c);

    // critical pin pulls low while any unmasked critical flag is set
    always_comb crit_drive_en = (lcrit & ~lcrit_mask) | (rcrit & rcrit_open_path);
endmodule

// File: rtl/thermal_alarm.sv
// Module: thermal_alarm (top)
// Compares each completed local or remote reading to its high limit and
// to the shared critical limit, keeps five sticky flags and drives the
// interrupt and critical alarm enables. An open remote input is treated
// as the largest positive reading. Assumes conv_done and stat_rd are
// single-cycle pulses and the limits and config are held stable.
module thermal_alarm
    import thermal_alarm_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_done,
    input  logic              conv_chan,
    input  logic [DATA_W-1:0] conv_value,
    input  logic              conv_open,
    input  logic [DATA_W-1:0] lim_local_high,
    input  logic [DATA_W-1:0] lim_remote_high,
    input  logic [DATA_W-1:0] lim_crit,
    input  logic [CFG_W-1:0]  cfg,
    input  logic              stat_rd,
    output logic [STAT_W-1:0] status,
    output logic              int_drive_en,
    output logic              crit_drive_en
);
    localparam logic [DATA_W-1:0] OPEN_CODE = {1'b0, {(DATA_W-1){1'b1}}};

    logic              evt_local;
    logic              evt_remote;
    logic              remote_is_open;
    logic [DATA_W-1:0] reading_eff;
    logic [DATA_W-1:0] cmp_lim [NUM_CMP];
    logic              cmp_hit [NUM_CMP];
    logic              fl_evt  [NUM_FLAG];
    logic              fl_cond [NUM_FLAG];
    logic              fl_q    [NUM_FLAG];
    logic              unused_cfg;

    // config bits with no function here
    always_comb unused_cfg = cfg[0] ^ cfg[6];

    // decode the completion strobe per channel
    always_comb begin
        evt_local  = conv_done & (conv_chan == CH_LOCAL);
        evt_remote = conv_done & (conv_chan == CH_REMOTE);
    end

    // an open remote input reads as the top positive code
    always_comb begin
        remote_is_open = (conv_chan == CH_REMOTE) & conv_open;
        reading_eff    = remote_is_open ? OPEN_CODE : conv_value;
    end

    // limit routing to the comparator slots
    always_comb begin
        cmp_lim[CM_LCRIT] = lim_crit;
        cmp_lim[CM_RCRIT] = lim_crit;
        cmp_lim[CM_RHIGH] = lim_remote_high;
        cmp_lim[CM_LHIGH] = lim_local_high;
    end

    generate
        for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
            limit_compare #(.W(DATA_W), .SIGNED_CMP(1'b1)) u_cmp (
                .reading (reading_eff),
                .limit   (cmp_lim[i]),
                .above   (cmp_hit[i])
            );
        end
    endgenerate

    // event and condition per flag slot
    always_comb begin
        fl_evt[FL_LCRIT]  = evt_local;
        fl_cond[FL_LCRIT] = cmp_hit[CM_LCRIT];
        fl_evt[FL_RCRIT]  = evt_remote;
        fl_cond[FL_RCRIT] = cmp_hit[CM_RCRIT];
        fl_evt[FL_ROPEN]  = evt_remote;
        fl_cond[FL_ROPEN] = conv_open;
        fl_evt[FL_RHIGH]  = evt_remote;
        fl_cond[FL_RHIGH] = cmp_hit[CM_RHIGH];
        fl_evt[FL_LHIGH]  = evt_local;
        fl_cond[FL_LHIGH] = cmp_hit[CM_LHIGH];
    end

    generate
        for (genvar f = 0; f < NUM_FLAG; f++) begin : g_flag
            sticky_flag u_flag (
                .clk   (clk),
                .rst_n (rst_n),
                .evt   (fl_evt[f]),
                .cond  (fl_cond[f]),
                .rd    (stat_rd),
                .flag  (fl_q[f])
            );
        end
    endgenerate

    // assemble the status byte; unused positions stay zero
    always_comb begin
        status           = '0;
        status[SB_LCRIT] = fl_q[FL_LCRIT];
        status[SB_RCRIT] = fl_q[FL_RCRIT];
        status[SB_ROPEN] = fl_q[FL_ROPEN];
        status[SB_RHIGH] = fl_q[FL_RHIGH];
        status[SB_LHIGH] = fl_q[FL_LHIGH];
    end

    alarm_drive u_drive (
        .lhigh         (fl_q[FL_LHIGH]),
        .rhigh         (fl_q[FL_RHIGH]),
        .lcrit         (fl_q[FL_LCRIT]),
        .rcrit         (fl_q[FL_RCRIT]),
        .int_mask      (cfg[CB_INT_MK]),
        .int_pol_high  (cfg[CB_INT_POL]),
        .lcrit_mask    (cfg[CB_LCRIT_MK]),
        .rcrit_mask_a  (cfg[CB_RCRIT_MA]),
        .rcrit_mask_b  (cfg[CB_RCRIT_MB]),
        .rcrit_mask_c  (cfg[CB_RCRIT_MC]),
        .int_drive_en  (int_drive_en),
        .crit_drive_en (crit_drive_en)
    );

    // R3
    local_high_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && conv_chan == CH_LOCAL &&
         $signed(conv_value) > $signed(lim_local_high)) |=> status[SB_LHIGH]);

    // R10
    open_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && conv_chan == CH_REMOTE && conv_open) |=> status[SB_ROPEN]);

    // R8
    int_polarity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg[CB_INT_MK] && (status[SB_RHIGH] || status[SB_LHIGH]))
        |-> (int_drive_en == !cfg[CB_INT_POL]));

    // R9
    crit_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        crit_drive_en |-> (status[SB_LCRIT] || status[SB_RCRIT]));

    // R7
    int_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg[CB_INT_MK] |-> (int_drive_en == cfg[CB_INT_POL]));
endmodule

// File: tb/thermal_alarm_bench.sv
// Scoreboard bench: the driver applies one cycle of stimulus, advances a
// requirement-level model and queues the expected outputs; the monitor
// pops and compares them 5 ns after each rising edge.
module thermal_alarm_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       conv_done = 1'b0;
    logic       conv_chan = 1'b0;
    logic [7:0] conv_value = 8'h00;
    logic       conv_open = 1'b0;
    logic [7:0] lim_local_high = 8'h7F;
    logic [7:0] lim_remote_high = 8'h7F;
    logic [7:0] lim_crit = 8'h7F;
    logic [7:0] cfg = 8'h00;
    logic       stat_rd = 1'b0;
    logic [7:0] status;
    logic       int_drive_en;
    logic       crit_drive_en;

    always #10 clk = ~clk;

    thermal_alarm u_thermal_alarm (
        .clk             (clk),
        .rst_n           (rst_n),
        .conv_done       (conv_done),
        .conv_chan       (conv_chan),
        .conv_value      (conv_value),
        .conv_open       (conv_open),
        .lim_local_high  (lim_local_high),
        .lim_remote_high (lim_remote_high),
        .lim_crit        (lim_crit),
        .cfg             (cfg),
        .stat_rd         (stat_rd),
        .status          (status),
        .int_drive_en    (int_drive_en),
        .crit_drive_en   (crit_drive_en)
    );

    typedef struct {
        logic [7:0] st;
        logic       ie;
        logic       ce;
        string      tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    bit   finished = 0;
    // model flags: 0 lcrit, 1 rcrit, 2 open, 3 rhigh, 4 lhigh
    bit   m_flag [5];
    bit   m_cond [5];

    function automatic exp_t expect_now(input string tag);
        exp_t e;
        bit   act;
        e.st  = {1'b0, m_flag[4], 1'b0, m_flag[3], 1'b0, m_flag[2], m_flag[1], m_flag[0]};
        act   = (m_flag[3] || m_flag[4]) && !cfg[7];
        e.ie  = cfg[1] ? !act : act;
        e.ce  = (m_flag[0] && !cfg[2]) || (m_flag[1] && !(cfg[3] || cfg[4] || cfg[5]));
        e.tag = tag;
        return e;
    endfunction

    task automatic model_step(input bit d, input bit ch, input logic [7:0] v,
                              input bit op, input bit rd);
        logic [7:0] ve;
        bit ev [5];
        bit c  [5];
        ve = (ch && op) ? 8'h7F : v;
        ev[0] = d && !ch; c[0] = $signed(ve) > $signed(lim_crit);
        ev[1] = d && ch;  c[1] = $signed(ve) > $signed(lim_crit);
        ev[2] = d && ch;  c[2] = op;
        ev[3] = d && ch;  c[3] = $signed(ve) > $signed(lim_remote_high);
        ev[4] = d && !ch; c[4] = $signed(ve) > $signed(lim_local_high);
        for (int i = 0; i < 5; i++) begin
            bit nc;
            nc = ev[i] ? c[i] : m_cond[i];
            m_flag[i] = (ev[i] && c[i]) || (m_flag[i] && !(rd && !nc));
            m_cond[i] = nc;
        end
    endtask

    task automatic cyc(input bit d, input bit ch, input logic [7:0] v,
                       input bit op, input bit rd, input string tag);
        @(negedge clk);
        conv_done  = d;
        conv_chan  = ch;
        conv_value = v;
        conv_open  = op;
        stat_rd    = rd;
        @(posedge clk);
        model_step(d, ch, v, op, rd);
        q.push_back(expect_now(tag));
        #1;
        conv_done = 1'b0;
        stat_rd   = 1'b0;
        conv_open = 1'b0;
    endtask

    task automatic idle(input string tag);
        cyc(1'b0, 1'b0, 8'h00, 1'b0, 1'b0, tag);
    endtask

    task automatic read_st(input string tag);
        cyc(1'b0, 1'b0, 8'h00, 1'b0, 1'b1, tag);
    endtask

    task automatic set_cfg(input logic [7:0] c);
        @(negedge clk);
        cfg = c;
    endtask

    task automatic set_lims(input logic [7:0] lh, input logic [7:0] rh,
                            input logic [7:0] cr);
        @(negedge clk);
        lim_local_high  = lh;
        lim_remote_high = rh;
        lim_crit        = cr;
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // monitor: compare queued expectations away from the clock edge
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (status !== e.st || int_drive_en !== e.ie || crit_drive_en !== e.ce) begin
                    errors++;
                    $display("FAIL %s: status=%02h int=%0b crit=%0b expected status=%02h int=%0b crit=%0b",
                             e.tag, status, int_drive_en, crit_drive_en, e.st, e.ie, e.ce);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            summary();
            $finish;
        end
    end

    // driver
    initial begin
        // R1: reset state, with a strobe held during reset
        conv_done  = 1'b1;
        conv_value = 8'h7E;
        repeat (3) @(posedge clk);
        q.push_back(expect_now("R1 in reset"));
        @(negedge clk);
        conv_done = 1'b0;
        rst_n     = 1'b1;
        idle("R1 after reset");

        set_lims(8'd40, 8'd60, 8'd100);
        // R3 / R2 local high at bit 6
        cyc(1, 0, 8'd50, 0, 0, "R3 local above high");
        cyc(1, 0, 8'd30, 0, 0, "R4 lower reading keeps flag");
        read_st("R5 read clears when latest below");
        cyc(1, 0, 8'd41, 0, 0, "R3 one above limit");
        cyc(1, 0, 8'd45, 0, 1, "R6 read with new exceedance");
        read_st("R5 read while latest exceeds keeps");
        cyc(1, 0, 8'd40, 0, 0, "R3 equal reading no set, R4 sticky");
        read_st("R5 clear after equal reading");

        // signed boundary cases
        set_lims(8'd10, 8'd60, 8'd100);
        cyc(1, 0, 8'hFF, 0, 0, "R3 signed -1 not above 10");
        set_lims(8'hF6, 8'd60, 8'd100);
        cyc(1, 0, 8'hF6, 0, 0, "R3 equal negative no set");
        cyc(1, 0, 8'hF7, 0, 0, "R3 -9 above -10");
        cyc(1, 0, 8'hF0, 0, 0, "R4 -16 keeps flag");
        read_st("R5 negative clear");

        // remote high at bit 4, interrupt mask and polarity
        cyc(1, 1, 8'd61, 0, 0, "R2 remote high bit 4");
        set_cfg(8'h80);
        idle("R7 interrupt masked, status kept");
        set_cfg(8'h02);
        idle("R8 active-high while active");
        cyc(1, 1, 8'd20, 0, 1, "R5 remote clear with lower reading");
        idle("R8 active-high while idle");
        set_cfg(8'h00);
        idle("R8 active-low while idle");

        // local critical and its mask
        cyc(1, 0, 8'd101, 0, 0, "R9 local critical");
        set_cfg(8'h04);
        idle("R9 local critical masked, status kept");
        set_cfg(8'h00);
        cyc(1, 0, 8'hF0, 0, 1, "R5 local crit and high clear");

        // remote critical and each remote mask
        cyc(1, 1, 8'd110, 0, 0, "R9 remote critical");
        set_cfg(8'h08);
        idle("R9 remote mask bit 3");
        set_cfg(8'h10);
        idle("R9 remote mask bit 4");
        set_cfg(8'h20);
        idle("R9 remote mask bit 5");
        set_cfg(8'h04);
        idle("R9 local mask leaves remote path");
        set_cfg(8'h00);
        cyc(1, 1, 8'd10, 0, 1, "R5 remote crit clear");

        // open remote input
        cyc(1, 1, 8'h00, 1, 0, "R10 open with critical 100");
        cyc(1, 1, 8'h00, 0, 1, "R10 clear after closed reading");
        set_lims(8'hF6, 8'd60, 8'h7F);
        cyc(1, 1, 8'h00, 1, 0, "R10 open with critical 127");
        read_st("R10 open stays while latest open");
        cyc(1, 1, 8'd5, 0, 0, "R4 open sticky after closed reading");
        read_st("R10 open clears after read");

        wait (q.size() == 0);
        repeat (2) @(posedge clk);
        finished = 1;
        summary();
        $finish;
    end
endmodule